// File: doc/BRIEF.md
# Streaming Maximum/Minimum Word Selector

The block takes K operand words at once, each word arriving on its own serial line with the most significant digit first. It produces the largest word (or, in minimum mode, the smallest) as a serial stream, one digit per clock. Each result digit appears one cycle after the digits it was decided from. No operand is ever stored whole. A candidate flag per input records whether that input can still be the winner. An input drops out as soon as it shows a 0 digit while another live input shows a 1 (in minimum mode the roles of 0 and 1 swap).

A word starts with a strobe that comes together with the MSB digits. The strobe re-arms every flag and samples the selection mode for that word. After W digits the block ignores its serial inputs until the next strobe. Words may follow each other with no idle cycle. When the word ends, the flags show which inputs held the winning value.

Top module: `msel_top`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, every flag reads 1 and `sel_bit` reads 0.
- R2: A cycle with `word_go`=1 treats all K inputs as candidates for the digit presented in that same cycle, whatever the flags held before.
- R3: In a word digit where every candidate shows the same value (all 0 or all 1), no flag changes.
- R4: In a word digit where candidates disagree, every candidate showing the losing value has its flag cleared. In max mode the losing value is 0; in min mode it is 1. A cleared flag stays cleared until the next strobe, and at least one flag is always set.
- R5: In max mode (`min_sel`=0 at the strobe), `sel_bit` in the cycle after a digit equals the OR of that digit over the candidates.
- R6: In min mode (`min_sel`=1 at the strobe), `sel_bit` in the cycle after a digit equals the AND of that digit over the candidates.
- R7: `min_sel` is sampled only in the strobe cycle. Changing it during the rest of the word has no effect on `sel_bit` or the flags.
- R8: After W digits with no new strobe, the serial inputs are ignored: the flags hold and `sel_bit` reads 0 until the next strobe.
- R9: Over one word, the W output digits spell the maximum (or minimum) operand MSB first. The final flags are 1 exactly for the inputs whose word equals that value, so ties leave several flags set.
- R10: A strobe may come in the cycle right after the last digit of the previous word, and both words are selected correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_go | input | 1 | Word-start strobe, given together with the MSB digits |
| min_sel | input | 1 | 1 selects minimum, 0 maximum; sampled at the strobe |
| ser_in | input | K | Current digit of each operand |
| sel_bit | output | 1 | Result digit, one cycle after its inputs |
| cand | output | K | Candidate flags, 1 while an input can still win |

## Verification
The bench sweeps every combination of three 3-bit operands in both modes, streaming the words back to back. This catches a design that re-arms the flags one cycle late, because its MSB decision would then use the previous word's survivors and give a wrong top digit. Sweeping all equal and tied operands exposes a design that drops tied candidates or that clears flags when all digits agree. Toggling the mode line after every MSB and feeding junk after the final word reveals a design that follows the mode input mid-word or keeps selecting past W digits. Such a design would give wrong result digits or flags that drift after the word.

// File: rtl/msel_pkg.sv
package msel_pkg;
  typedef enum logic {
    SEL_MAX = 1'b0,
    SEL_MIN = 1'b1
  } sel_mode_e;
endpackage

// File: rtl/msel_rst_sync.sv
module msel_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/msel_seq.sv
module msel_seq
  import msel_pkg::*;
#(
  parameter int W = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      word_go,
  input  logic      min_sel,
  output logic      in_word,
  output sel_mode_e mode_eff
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  logic [CW-1:0] cnt_q, cnt_d;
  sel_mode_e     mode_q, mode_d;
  logic          cnt_en;

  always_comb begin
    cnt_d    = cnt_q;
    mode_d   = mode_q;
    cnt_en   = 1'b0;
    in_word  = 1'b0;
    mode_eff = mode_q;
    if (word_go) begin
      in_word  = 1'b1;
      cnt_en   = 1'b1;
      cnt_d    = CW'(1);
      mode_d   = sel_mode_e'(min_sel);
      mode_eff = sel_mode_e'(min_sel);
    end else if (cnt_q < LAST) begin
      in_word = 1'b1;
      cnt_en  = 1'b1;
      cnt_d   = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST;
      mode_q <= SEL_MAX;
    end else if (cnt_en) begin
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/msel_slice.sv
module msel_slice
  import msel_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      in_word,
  input  logic      arm,
  input  logic      any_hi,
  input  logic      digit,
  input  sel_mode_e mode_eff,
  output logic      contrib,
  output logic      flag
);
  logic flag_q, flag_d, live, norm;

  always_comb begin
    norm    = digit ^ logic'(mode_eff);
    live    = arm | flag_q;
    contrib = live & norm;
    flag_d  = flag_q;
    if (in_word) flag_d = live & (norm | ~any_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b1;
    else if (in_word) flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/msel_top.sv
module msel_top
  import msel_pkg::*;
#(
  parameter int K = 4,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_go,
  input  logic         min_sel,
  input  logic [K-1:0] ser_in,
  output logic         sel_bit,
  output logic [K-1:0] cand
);
  logic         rst_core_n;
  logic         in_word;
  sel_mode_e    mode_eff;
  logic [K-1:0] contrib;
  logic         any_hi;
  logic         bit_q, bit_d;

  msel_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(rst_core_n)
  );

  msel_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .word_go(word_go), .min_sel(min_sel),
    .in_word(in_word), .mode_eff(mode_eff)
  );

  assign any_hi = |contrib;

  for (genvar i = 0; i < K; i++) begin : g_slice
    msel_slice u_slice (
      .clk(clk), .rst_n(rst_core_n), .in_word(in_word), .arm(word_go),
      .any_hi(any_hi), .digit(ser_in[i]), .mode_eff(mode_eff),
      .contrib(contrib[i]), .flag(cand[i])
    );
  end

  always_comb begin
    bit_d = 1'b0;
    if (in_word) bit_d = any_hi ^ logic'(mode_eff);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) bit_q <= 1'b0;
    else             bit_q <= bit_d;
  end

  assign sel_bit = bit_q;
endmodule

// File: rtl/msel_checker.sv
module msel_checker #(
  parameter int K = 4
) (
  input logic         clk,
  input logic         rst_core_n,
  input logic         word_go,
  input logic         min_sel,
  input logic [K-1:0] ser_in,
  input logic         sel_bit,
  input logic [K-1:0] cand
);
  assert_no_revive_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !word_go |=> ((cand & ~$past(cand)) == '0));

  assert_survivor_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $countones(cand) >= 1);

  assert_rearm_all_agree_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (word_go && (ser_in == '0 || ser_in == '1)) |=> (cand == '1));

  assert_max_msb_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (word_go && !min_sel) |=> (sel_bit == |$past(ser_in)));

  assert_min_msb_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (word_go && min_sel) |=> (sel_bit == &$past(ser_in)));

  assert_rearm_max_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (word_go && !min_sel && ser_in != '0) |=> (cand == $past(ser_in)));
endmodule

bind msel_top msel_checker #(.K(K)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .word_go(word_go), .min_sel(min_sel),
  .ser_in(ser_in), .sel_bit(sel_bit), .cand(cand)
);

// File: tb/tb_msel_top.sv
module tb_msel_top;
  localparam int K = 3;
  localparam int W = 3;

  logic         clk;
  logic         rst_n;
  logic         word_go;
  logic         min_sel;
  logic [K-1:0] ser_in;
  logic         sel_bit;
  logic [K-1:0] cand;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  msel_top #(.K(K), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .word_go(word_go), .min_sel(min_sel),
    .ser_in(ser_in), .sel_bit(sel_bit), .cand(cand)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_word(input int a, input int b, input int c, input bit md);
    int ops[K];
    int best;
    int fl;
    ops[0] = a; ops[1] = b; ops[2] = c;
    best = a;
    for (int i = 1; i < K; i++)
      if (md ? (ops[i] < best) : (ops[i] > best)) best = ops[i];
    fl = 0;
    for (int i = 0; i < K; i++) if (ops[i] == best) fl |= (1 << i);
    for (int d = W - 1; d >= 0; d--) begin
      @(negedge clk);
      word_go = (d == W - 1);
      min_sel = (d == W - 1) ? md : ~md;  // R7: mode flips mid-word
      for (int i = 0; i < K; i++) ser_in[i] = ops[i][d];
      @(posedge clk);
      #2;
      check(md ? "R6/R7/R10 result digit" : "R5/R7/R10 result digit",
            int'(sel_bit), (best >> d) & 1);
    end
    check("R9 final flags", int'(cand), fl);
  endtask

  initial begin
    rst_n = 1'b0; word_go = 1'b0; min_sel = 1'b0; ser_in = '0;
    repeat (3) @(negedge clk);
    check("R1 reset flags", int'(cand), (1 << K) - 1);
    check("R1 reset output", int'(sel_bit), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 flags after release", int'(cand), (1 << K) - 1);
    check("R1 output after release", int'(sel_bit), 0);
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          for (int c = 0; c < (1 << W); c++)
            run_word(a, b, c, bit'(m));
    // R8: junk digits after the last word are ignored
    run_word(2, 5, 1, 1'b0);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      word_go = 1'b0;
      min_sel = j[0];
      ser_in  = K'(j + 1);
      @(posedge clk);
      #2;
      check("R8 flags hold", int'(cand), 3'b010);
      check("R8 output idle", int'(sel_bit), 0);
    end
    // R2: strobe re-arms flags cleared by the previous word
    run_word(7, 7, 7, 1'b0);
    check("R2 re-arm to full tie", int'(cand), 3'b111);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule